// File: doc/BRIEF.md
# Programmable Skew Clock Tap Generator

This block produces four pairs of output clocks from one fast timing clock. The timing clock ticks once per timing unit. One undivided output period is sixteen ticks long. A free-running tick counter defines a reference-aligned zero-skew clock. Each pair takes a four-bit control code made of two three-level digits. The code either moves the pair's clock earlier or later than the zero-skew clock by a whole number of ticks, or gives the pair a divided or inverted version of it.

Pairs 1 and 2 step in single ticks. Pairs 3 and 4 step in double ticks, and they use their two extreme codes for frequency division or inversion. A new control code is adopted only at the end of a zero-skew cycle, so a code change in the middle of a cycle never produces a runt pulse.

Top module: `skew_tap_gen`

## Requirements
- R1: While reset is high every output is low. After reset every pair acts as code MM (zero skew) for ticks 0 to 15, whatever its inputs carry.
- R2: Tick t is numbered from 0 at the first rising clock edge after reset falls. After edge t, a pair whose effective code is MM is high exactly when (t mod 16) >= 8.
- R3: Pair n uses pairCodes[4n-1:4n-2] as its first digit and pairCodes[4n-3:4n-4] as its second, with digit encoding LOW=00, MID=01, HIGH=10. The code index is 3*first+second, with values 0 to 8. For pairs 1 and 2 the skew is s = index-4 ticks, and after edge t the pair is high exactly when ((t-8-s) mod 16) < 8.
- R4: For pairs 3 and 4 with index 1 to 7, the skew is s = 2*(index-4) ticks, with the same waveform rule as R3.
- R5: For pairs 3 and 4, code LL (index 0) gives half frequency: the pair is high exactly when ((t-8) mod 32) < 16. Its rising edges coincide with rising edges of the zero-skew clock.
- R6: For pair 3, code HH (index 8) gives quarter frequency: the pair is high exactly when ((t-8) mod 64) < 32.
- R7: For pair 4, code HH gives the inverse of the zero-skew clock: the pair is high exactly when (t mod 16) < 8.
- R8: The two outputs of a pair, clkOut[2n-1] and clkOut[2n-2], always carry the same value.
- R9: The code present on the inputs at the edge of a tick with t mod 16 = 15 governs ticks t+1 through t+16. Code changes at any other edge have no effect on the outputs.
- R10: A digit value of 11 reads as MID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock, one tick per timing unit |
| rst | input | 1 | Synchronous active-high reset |
| pairCodes | input | 16 | Four control codes, pair n in bits [4n-1:4n-4], first digit in the upper half |
| clkOut | output | 8 | Output clocks, pair n on bits [2n-1:2n-2] |

## Verification
The hardest situation to reach is a code change that lands part way through a zero-skew cycle. It must stay invisible until the boundary, and it must then take effect on exactly the right tick. The stimulus moves the codes every few ticks at offsets that do not line up with the sixteen-tick period, so changes arrive at many different phases. A scoreboard models each pending change and the cycle in which it becomes effective. The quarter-rate mode only shows its alignment over a full 64-tick span, so it is held for several of those spans. Non-default codes are also applied during reset, which shows whether the first cycle after reset really runs at zero skew.

// File: rtl/skew_tap_pkg.sv
package skew_tap_pkg;

  localparam int NUM_PAIRS_DEF  = 4;
  localparam int PHASE_BITS_DEF = 4;

  typedef enum logic [1:0] {
    MODE_SKEW = 2'd0,
    MODE_DIV2 = 2'd1,
    MODE_DIV4 = 2'd2,
    MODE_INV  = 2'd3
  } tapMode_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic cycleEnd;   // last tick of a zero-skew cycle
    logic cycleStart; // first tick of a zero-skew cycle
  } ctrlStrobe_t;

  // Three-level digit: 00 low, 10 high, anything else mid
  function automatic logic [1:0] digitVal(input logic [1:0] d);
    case (d)
      2'b00:   digitVal = 2'd0;
      2'b10:   digitVal = 2'd2;
      default: digitVal = 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/skew_tap_ctrl.sv
module skew_tap_ctrl
  import skew_tap_pkg::*;
#(
  parameter int PHASE_BITS = PHASE_BITS_DEF,
  localparam int TICK_BITS = PHASE_BITS + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [TICK_BITS-1:0] tick,
  output ctrlStrobe_t          strobe
);

  logic [TICK_BITS-1:0] tickCnt;

  always_ff @(posedge clk) begin
    if (rst) tickCnt <= '0;
    else     tickCnt <= tickCnt + 1'b1;
  end

  assign tick              = tickCnt;
  assign strobe.cycleEnd   = &tickCnt[PHASE_BITS-1:0];
  assign strobe.cycleStart = ~|tickCnt[PHASE_BITS-1:0];

endmodule

// File: rtl/skew_tap_dp.sv
module skew_tap_dp
  import skew_tap_pkg::*;
#(
  parameter int NUM_PAIRS  = NUM_PAIRS_DEF,
  parameter int PHASE_BITS = PHASE_BITS_DEF,
  localparam int TICK_BITS = PHASE_BITS + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [TICK_BITS-1:0]   tick,
  input  ctrlStrobe_t            strobe,
  input  logic [4*NUM_PAIRS-1:0] pairCodes,
  output logic [4*NUM_PAIRS-1:0] activeCodes,
  output logic [2*NUM_PAIRS-1:0] clkOut
);

  localparam logic [TICK_BITS-1:0] HALF_TICKS = TICK_BITS'(1 << (PHASE_BITS - 1));
  localparam logic [3:0]           CODE_MID   = 4'b0101;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [3:0]           activeCode;
    logic [3:0]           codeIdx;
    logic [1:0]           hiVal, loVal;
    logic [TICK_BITS-1:0] skewTicks;
    logic [TICK_BITS-1:0] phaseDiff;
    tapMode_e             mode;
    logic                 level, outReg;

    always_ff @(posedge clk) begin
      if (rst)                  activeCode <= CODE_MID;
      else if (strobe.cycleEnd) activeCode <= pairCodes[4*p +: 4];
    end

    always_comb begin
      hiVal     = digitVal(activeCode[3:2]);
      loVal     = digitVal(activeCode[1:0]);
      codeIdx   = {1'b0, hiVal, 1'b0} + {2'b00, hiVal} + {2'b00, loVal};
      mode      = MODE_SKEW;
      skewTicks = TICK_BITS'(codeIdx) - TICK_BITS'(4);
      if (p >= 2) begin
        skewTicks = skewTicks << 1;
        if (codeIdx == 4'd0) begin
          mode      = MODE_DIV2;
          skewTicks = '0;
        end else if (codeIdx == 4'd8) begin
          mode      = (p == 2) ? MODE_DIV4 : MODE_INV;
          skewTicks = '0;
        end
      end
      phaseDiff = tick - HALF_TICKS - skewTicks;
      case (mode)
        MODE_DIV2: level = ~phaseDiff[PHASE_BITS];
        MODE_DIV4: level = ~phaseDiff[PHASE_BITS+1];
        MODE_INV:  level =  phaseDiff[PHASE_BITS-1];
        default:   level = ~phaseDiff[PHASE_BITS-1];
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) outReg <= 1'b0;
      else     outReg <= level;
    end

    assign clkOut[2*p +: 2]      = {2{outReg}};
    assign activeCodes[4*p +: 4] = activeCode;
  end

endmodule

// File: rtl/skew_tap_gen.sv
module skew_tap_gen
  import skew_tap_pkg::*;
#(
  parameter int NUM_PAIRS  = NUM_PAIRS_DEF,
  parameter int PHASE_BITS = PHASE_BITS_DEF,
  localparam int TICK_BITS = PHASE_BITS + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [4*NUM_PAIRS-1:0] pairCodes,
  output logic [2*NUM_PAIRS-1:0] clkOut
);

  logic [TICK_BITS-1:0]   tickBus;
  ctrlStrobe_t            strobe;
  logic [4*NUM_PAIRS-1:0] activeCodes;

  skew_tap_ctrl #(.PHASE_BITS(PHASE_BITS)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .tick   (tickBus),
    .strobe (strobe)
  );

  skew_tap_dp #(.NUM_PAIRS(NUM_PAIRS), .PHASE_BITS(PHASE_BITS)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .tick        (tickBus),
    .strobe      (strobe),
    .pairCodes   (pairCodes),
    .activeCodes (activeCodes),
    .clkOut      (clkOut)
  );

endmodule

// File: rtl/skew_tap_gen_chk.sv
module skew_tap_gen_chk #(
  parameter int NUM_PAIRS  = 4,
  parameter int PHASE_BITS = 4,
  localparam int TICK_BITS = PHASE_BITS + 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic [2*NUM_PAIRS-1:0] clkOut,
  input logic [TICK_BITS-1:0]   tick,
  input logic                   cycleEnd,
  input logic [4*NUM_PAIRS-1:0] activeCodes
);

  localparam logic [PHASE_BITS-1:0] HALF = PHASE_BITS'(1 << (PHASE_BITS - 1));

  logic [PHASE_BITS-1:0] ph;
  assign ph = tick[PHASE_BITS-1:0];

  AST_CODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !$past(cycleEnd) |-> $stable(activeCodes)); // R9

  AST_ZERO_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(clkOut[0]) && activeCodes[3:0] == 4'b0101 && $stable(activeCodes[3:0]))
      |-> $past(ph) == HALF); // R2

  AST_DIV2_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(clkOut[4]) && activeCodes[11:8] == 4'b0000 && $stable(activeCodes[11:8]))
      |-> $past(ph) == HALF); // R5

  AST_DIV4_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(clkOut[4]) && activeCodes[11:8] == 4'b1010 && $stable(activeCodes[11:8]))
      |-> $past(ph) == HALF); // R6

  AST_INV_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (activeCodes[15:12] == 4'b1010 && $stable(activeCodes[15:12]))
      |-> clkOut[6] == ($past(ph) < HALF)); // R7

endmodule

bind skew_tap_gen skew_tap_gen_chk #(.NUM_PAIRS(NUM_PAIRS), .PHASE_BITS(PHASE_BITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .clkOut      (clkOut),
  .tick        (tickBus),
  .cycleEnd    (strobe.cycleEnd),
  .activeCodes (activeCodes)
);

// File: tb/skew_tap_gen_bench.sv
module skew_tap_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pairCodes = 16'h5555;
  logic [7:0]  clkOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    int          t;
    logic [7:0]  expv;
    logic [15:0] act;
    logic [15:0] raw;
  } item_t;

  item_t       sbq[$];
  logic [15:0] modelAct = 16'h5555;
  int          modelT   = 0;

  always #2 clk = ~clk;

  skew_tap_gen u_skew_tap_gen (
    .clk       (clk),
    .rst       (rst),
    .pairCodes (pairCodes),
    .clkOut    (clkOut)
  );

  function automatic int dv(input logic [1:0] d);
    if (d == 2'b00) return 0;
    if (d == 2'b10) return 2;
    return 1;
  endfunction

  function automatic logic expLevel(input int p, input logic [3:0] c, input int t);
    int i = 3 * dv(c[3:2]) + dv(c[1:0]);
    int s;
    if (p < 2) begin
      s = i - 4;
      return ((t + 64 - 8 - s) % 16) < 8;
    end
    if (i == 0) return ((t + 64 - 8) % 32) < 16;
    if (i == 8) return (p == 2) ? (((t + 64 - 8) % 64) < 32) : ((t % 16) < 8);
    s = 2 * (i - 4);
    return ((t + 64 - 8 - s) % 16) < 8;
  endfunction

  function automatic string tagFor(input int p, input item_t it);
    logic [3:0] c = it.act[4*p +: 4];
    int i = 3 * dv(c[3:2]) + dv(c[1:0]);
    if (it.t < 16) return "R1";
    if (it.raw[4*p +: 4] != c) return "R9";
    if (c[3:2] == 2'b11 || c[1:0] == 2'b11) return "R10";
    if (p < 2) return (i == 4) ? "R2" : "R3";
    if (i == 0) return "R5";
    if (i == 8) return (p == 2) ? "R6" : "R7";
    return "R4";
  endfunction

  // Driver: one expected item per tick
  task automatic runTicks(input int n);
    item_t it;
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      it.t   = modelT;
      it.act = modelAct;
      it.raw = pairCodes;
      for (int p = 0; p < 4; p++)
        it.expv[2*p +: 2] = {2{expLevel(p, modelAct[4*p +: 4], modelT)}};
      sbq.push_back(it);
      if (modelT % 16 == 15) modelAct = pairCodes;
      modelT++;
    end
  endtask

  task automatic setCodes(input logic [15:0] v);
    @(negedge clk);
    pairCodes = v;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      for (int p = 0; p < 4; p++) begin
        checks++;
        if (clkOut[2*p +: 2] != it.expv[2*p +: 2]) begin
          errors++;
          $display("FAIL %s t=%0d pair%0d got %b exp %b", tagFor(p, it), it.t, p + 1,
                   clkOut[2*p +: 2], it.expv[2*p +: 2]);
        end
        checks++;
        if (clkOut[2*p] != clkOut[2*p+1]) begin
          errors++;
          $display("FAIL R8 t=%0d pair%0d got %b exp equal bits", it.t, p + 1, clkOut[2*p +: 2]);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout exp finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Non-default codes during reset must not matter (R1)
    pairCodes = 16'hAA00;
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (clkOut !== 8'h00) begin
        errors++;
        $display("FAIL R1 reset got %b exp 00000000", clkOut);
      end
    end
    @(negedge clk);
    rst = 1'b0;
    runTicks(21);                    // first cycle zero skew, then new codes mid-cycle
    for (int i = 0; i < 9; i++) begin
      logic [1:0] hi = (i / 3 == 0) ? 2'b00 : (i / 3 == 1) ? 2'b01 : 2'b10;
      logic [1:0] lo = (i % 3 == 0) ? 2'b00 : (i % 3 == 1) ? 2'b01 : 2'b10;
      setCodes({4{hi, lo}});         // R3 R4 R5 R6 R7 sweep
      runTicks(47);
    end
    setCodes(16'h1A0A);              // R6 quarter rate on pair 3, long hold
    runTicks(140);
    setCodes(16'hF7DE);              // R10 digit 11 as mid
    runTicks(40);
    for (int k = 0; k < 30; k++) begin   // R9 changes at scattered phases
      setCodes(16'(k * 16'h3B6D + 16'h2491));
      runTicks(3 + (k % 5) * 2);
    end
    setCodes(16'h0000);              // R5 pairs 3 and 4 half rate
    runTicks(80);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule